// File: doc/BRIEF.md
# RMII Receive Frame Capture

This block receives Ethernet frames from a 100 Mbit/s RMII PHY. On every rising edge of the 50 MHz reference clock it samples the two receive data lines and the carrier-sense line. While carrier is present it first searches for the preamble and the start-of-frame delimiter. After the delimiter it packs each group of four dibits into a byte and issues one write per byte into a frame buffer, using the byte index as the write address.

There is no length field. When carrier sense drops, the frame is over. The block then raises a one-cycle completion strobe and reports the byte count from its write cursor, together with a flag that says whether the frame was larger than the buffer. A host picks up the frame from the buffer at its own pace.

Unwanted line activity is filtered out. This covers a burst with a bad start, a burst with no preamble, and a carrier that drops during the preamble. In each case the block writes nothing and reports nothing. It waits for a fresh rise of carrier before it searches again.

Top module: `rmii_rx_capture`

## Requirements
- R1: While `rstN` is low, and in the first cycle after it is released, `wrEn` and `frameDone` are 0.
- R2: A frame starts when carrier is high and the dibit 11 arrives after one or more preamble dibits of value 01, where rxd[0] carries bit 0. Any preamble length of one dibit or more is accepted. While hunting with carrier high, the dibit 00 is tolerated and hunting continues.
- R3: Data dibits fill each byte from the least significant end: the first dibit becomes bits [1:0] and the fourth becomes bits [7:6]. `wrEn` is high for one cycle, in the cycle after the edge that samples the fourth dibit. `wrAddr` counts 0, 1, 2 and so on from the start of the frame.
- R4: Carrier sampled low during data capture produces a one-cycle `frameDone` pulse in the next cycle. `frameLen` then equals the number of whole bytes received. `frameLen` and `frameOvf` hold their values until the next completion.
- R5: If carrier drops after one to three dibits of a byte, that partial byte is neither written nor counted.
- R6: `frameLen` saturates at 2^LEN_W - 1, which is 2047 by default.
- R7: Bytes with an index of BUF_BYTES or more are not written. `frameOvf` is 1 exactly when the frame holds more than BUF_BYTES bytes.
- R8: A start is invalid if, while carrier is high, the hunt sees a dibit other than 00 or 01, or if a preamble is followed by 10 or 00. After an invalid start, all data is ignored (no write, no completion) until carrier has gone low and high again.
- R9: If carrier drops during the preamble, the block returns to hunting without a write or a completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 50 MHz reference clock |
| rstN | input | 1 | Synchronous active-low reset |
| rxd | input | 2 | Receive dibit; rxd[0] is the lower bit |
| crs | input | 1 | Carrier sense from the PHY |
| wrEn | output | 1 | Byte write strobe to the frame buffer |
| wrAddr | output | LEN_W | Byte index within the frame |
| wrData | output | 8 | Assembled byte |
| frameDone | output | 1 | One-cycle end-of-frame strobe |
| frameLen | output | LEN_W | Byte count of the last frame, saturating |
| frameOvf | output | 1 | Last frame exceeded the buffer |

## Verification
The bench sweeps preamble lengths of one to many dibits. For each it tries frame sizes of zero bytes, a few bytes, and the buffer size minus one, exactly, and plus one. It also cuts carrier at every position inside a byte.

- A design that miscounted the delimiter would shift every byte by one or two dibits and fail the data comparison.
- A design that counted a trailing partial byte would report a length one too high.
- A design with an off-by-one buffer limit would write into, or flag, the wrong byte.

A 2100-byte frame exposes a length counter that wraps instead of saturating. Bad starts, starts with no preamble, and carrier drops during the preamble are each followed by a valid frame. A design that kept stale state would then write garbage or lose that next frame.

// File: rtl/rmii_rx_pkg.sv
package rmii_rx_pkg;

  typedef enum logic [1:0] {
    ST_HUNT,
    ST_PRE,
    ST_DATA,
    ST_SKIP
  } rxState_t;

  typedef struct packed {
    logic startFrame;
    logic shiftEn;
    logic endFrame;
  } rxCtrl_t;

endpackage

// File: rtl/rmii_rx_ctrl.sv
module rmii_rx_ctrl
  import rmii_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] rxd,
  input  logic       crs,
  output rxCtrl_t    ctrl
);

  localparam logic [1:0] DIBIT_PRE = 2'b01;
  localparam logic [1:0] DIBIT_SFD = 2'b11;
  localparam logic [1:0] DIBIT_IDLE = 2'b00;

  rxState_t state, nextState;

  always_comb begin
    nextState = state;
    ctrl = '0;
    unique case (state)
      ST_HUNT: begin
        if (crs) begin
          if (rxd == DIBIT_PRE) nextState = ST_PRE;
          else if (rxd != DIBIT_IDLE) nextState = ST_SKIP;
        end
      end
      ST_PRE: begin
        if (!crs) begin
          nextState = ST_HUNT;
        end else if (rxd == DIBIT_SFD) begin
          nextState = ST_DATA;
          ctrl.startFrame = 1'b1;
        end else if (rxd != DIBIT_PRE) begin
          nextState = ST_SKIP;
        end
      end
      ST_DATA: begin
        if (crs) begin
          ctrl.shiftEn = 1'b1;
        end else begin
          ctrl.endFrame = 1'b1;
          nextState = ST_HUNT;
        end
      end
      ST_SKIP: begin
        if (!crs) nextState = ST_HUNT;
      end
      default: nextState = ST_HUNT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_HUNT;
    else state <= nextState;
  end

endmodule

// File: rtl/rmii_rx_path.sv
module rmii_rx_path
  import rmii_rx_pkg::*;
#(
  parameter int LEN_W = 11,
  parameter int BUF_BYTES = 1536
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       rxd,
  input  rxCtrl_t          ctrl,
  output logic             wrEn,
  output logic [LEN_W-1:0] wrAddr,
  output logic [7:0]       wrData,
  output logic             frameDone,
  output logic [LEN_W-1:0] frameLen,
  output logic             frameOvf
);

  localparam logic [LEN_W-1:0] MAX_LEN = {LEN_W{1'b1}};
  localparam logic [LEN_W-1:0] BUF_LIM = LEN_W'(BUF_BYTES);

  logic [5:0]       partial;
  logic [1:0]       dibitCnt;
  logic [LEN_W-1:0] byteCnt;
  logic             ovf;
  logic             byteDone;
  logic [7:0]       fullByte;

  assign byteDone = ctrl.shiftEn && (dibitCnt == 2'd3);
  assign fullByte = {rxd, partial};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      partial  <= '0;
      dibitCnt <= '0;
      byteCnt  <= '0;
      ovf      <= 1'b0;
    end else if (ctrl.startFrame) begin
      dibitCnt <= '0;
      byteCnt  <= '0;
      ovf      <= 1'b0;
    end else if (ctrl.shiftEn) begin
      partial  <= {rxd, partial[5:2]};
      dibitCnt <= dibitCnt + 2'd1;
      if (byteDone) begin
        if (byteCnt != MAX_LEN) byteCnt <= byteCnt + 1'b1;
        if (byteCnt >= BUF_LIM) ovf <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrEn      <= 1'b0;
      wrAddr    <= '0;
      wrData    <= '0;
      frameDone <= 1'b0;
      frameLen  <= '0;
      frameOvf  <= 1'b0;
    end else begin
      wrEn      <= 1'b0;
      frameDone <= 1'b0;
      if (byteDone && (byteCnt < BUF_LIM)) begin
        wrEn   <= 1'b1;
        wrAddr <= byteCnt;
        wrData <= fullByte;
      end
      if (ctrl.endFrame) begin
        frameDone <= 1'b1;
        frameLen  <= byteCnt;
        frameOvf  <= ovf;
      end
    end
  end

endmodule

// File: rtl/rmii_rx_capture.sv
module rmii_rx_capture
  import rmii_rx_pkg::*;
#(
  parameter int LEN_W = 11,
  parameter int BUF_BYTES = 1536
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       rxd,
  input  logic             crs,
  output logic             wrEn,
  output logic [LEN_W-1:0] wrAddr,
  output logic [7:0]       wrData,
  output logic             frameDone,
  output logic [LEN_W-1:0] frameLen,
  output logic             frameOvf
);

  rxCtrl_t ctrl;

  rmii_rx_ctrl uCtrl (
    .clk  (clk),
    .rstN (rstN),
    .rxd  (rxd),
    .crs  (crs),
    .ctrl (ctrl)
  );

  rmii_rx_path #(
    .LEN_W     (LEN_W),
    .BUF_BYTES (BUF_BYTES)
  ) uPath (
    .clk       (clk),
    .rstN      (rstN),
    .rxd       (rxd),
    .ctrl      (ctrl),
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .frameDone (frameDone),
    .frameLen  (frameLen),
    .frameOvf  (frameOvf)
  );

endmodule

// File: rtl/rmii_rx_chk.sv
module rmii_rx_chk #(
  parameter int LEN_W = 11,
  parameter int BUF_BYTES = 1536
) (
  input logic             clk,
  input logic             rstN,
  input logic             crs,
  input logic             wrEn,
  input logic [LEN_W-1:0] wrAddr,
  input logic             frameDone,
  input logic [LEN_W-1:0] frameLen,
  input logic             frameOvf
);

  // R3
  wr_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> !wrEn);

  // R3
  wr_needs_crs_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> $past(crs));

  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> !frameDone);

  // R4
  done_after_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |-> !$past(crs));

  // R4
  len_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!frameDone && $past(rstN)) |-> ($stable(frameLen) && $stable(frameOvf)));

  // R7
  wr_in_buf_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> (int'(wrAddr) < BUF_BYTES));

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (frameDone && int'(frameLen) > BUF_BYTES) |-> frameOvf);

  // R7
  ovf_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    (frameDone && frameOvf) |-> (int'(frameLen) > BUF_BYTES));

endmodule

bind rmii_rx_capture rmii_rx_chk #(
  .LEN_W     (LEN_W),
  .BUF_BYTES (BUF_BYTES)
) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .crs       (crs),
  .wrEn      (wrEn),
  .wrAddr    (wrAddr),
  .frameDone (frameDone),
  .frameLen  (frameLen),
  .frameOvf  (frameOvf)
);

// File: tb/sim_rmii_rx_capture.sv
module sim_rmii_rx_capture;

  localparam int LEN_W = 11;
  localparam int BUF_BYTES = 64;
  localparam int MAX_LEN = (1 << LEN_W) - 1;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [1:0]       rxd = 2'b00;
  logic             crs = 1'b0;
  logic             wrEn;
  logic [LEN_W-1:0] wrAddr;
  logic [7:0]       wrData;
  logic             frameDone;
  logic [LEN_W-1:0] frameLen;
  logic             frameOvf;

  int testCnt = 0;
  int failCnt = 0;
  int curSeed = 0;
  int monIdx = 0;
  int wrCount = 0;
  int doneSeen = 0;

  always #2 clk = ~clk;

  rmii_rx_capture #(.LEN_W(LEN_W), .BUF_BYTES(BUF_BYTES)) u0 (
    .clk(clk), .rstN(rstN), .rxd(rxd), .crs(crs),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .frameDone(frameDone), .frameLen(frameLen), .frameOvf(frameOvf)
  );

  function automatic logic [7:0] patByte(input int seed, input int idx);
    return 8'(idx * 37 + seed * 11 + 5);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Write monitor: each write must carry the next index and its pattern byte (R3, R7)
  always @(posedge clk) begin
    #1;
    if (rstN && wrEn) begin
      chk(int'(wrAddr) == monIdx, "R3 wrAddr", int'(wrAddr), monIdx);
      chk(wrData == patByte(curSeed, monIdx), "R3 wrData", int'(wrData),
          int'(patByte(curSeed, monIdx)));
      monIdx++;
      wrCount++;
    end
    if (rstN && frameDone) doneSeen++;
  end

  task automatic dib(input logic [1:0] d, input logic c);
    @(negedge clk);
    rxd = d;
    crs = c;
  endtask

  task automatic sendFrame(input int preLen, input int nBytes, input int extra, input int seed);
    int expLen;
    int expWr;
    curSeed = seed;
    monIdx = 0;
    wrCount = 0;
    doneSeen = 0;
    for (int i = 0; i < preLen; i++) dib(2'b01, 1'b1);
    dib(2'b11, 1'b1);
    for (int b = 0; b < nBytes; b++) begin
      logic [7:0] v;
      v = patByte(seed, b);
      for (int k = 0; k < 4; k++) dib(v[2*k +: 2], 1'b1);
    end
    for (int e = 0; e < extra; e++) dib(2'b10, 1'b1);
    dib(2'b00, 1'b0);
    @(posedge clk);
    #2;
    expLen = (nBytes > MAX_LEN) ? MAX_LEN : nBytes;
    expWr = (nBytes > BUF_BYTES) ? BUF_BYTES : nBytes;
    // R4 R5 R6: completion strobe and length of whole bytes
    chk(frameDone == 1'b1, "R4 frameDone", int'(frameDone), 1);
    chk(int'(frameLen) == expLen, "R4/R5/R6 frameLen", int'(frameLen), expLen);
    // R7: overflow flag and write count
    chk(frameOvf == (nBytes > BUF_BYTES), "R7 frameOvf", int'(frameOvf),
        int'(nBytes > BUF_BYTES));
    chk(wrCount == expWr, "R7 write count", wrCount, expWr);
    chk(doneSeen == 1, "R4 single done", doneSeen, 1);
    dib(2'b00, 1'b0);
    dib(2'b00, 1'b0);
  endtask

  // kind 0: preamble then 10 (R8); kind 1: 11 with no preamble (R8);
  // kind 2: carrier drop in preamble (R9); kind 3: 00 at carrier rise then 10 (R2/R8)
  task automatic badStart(input int kind);
    wrCount = 0;
    doneSeen = 0;
    curSeed = 0;
    monIdx = 0;
    case (kind)
      0: begin
        dib(2'b01, 1'b1); dib(2'b01, 1'b1); dib(2'b10, 1'b1);
      end
      1: begin
        dib(2'b11, 1'b1);
      end
      2: begin
        dib(2'b01, 1'b1); dib(2'b01, 1'b1); dib(2'b01, 1'b0);
      end
      default: begin
        dib(2'b00, 1'b1); dib(2'b10, 1'b1);
      end
    endcase
    // a well-formed start and data while carrier stays high must be ignored
    if (kind != 2) begin
      dib(2'b01, 1'b1); dib(2'b01, 1'b1); dib(2'b11, 1'b1);
      for (int i = 0; i < 16; i++) dib(2'(i), 1'b1);
    end
    dib(2'b00, 1'b0);
    dib(2'b00, 1'b0);
    dib(2'b00, 1'b0);
    @(posedge clk);
    #2;
    chk(wrCount == 0, (kind == 2) ? "R9 no write" : "R8 no write", wrCount, 0);
    chk(doneSeen == 0, (kind == 2) ? "R9 no done" : "R8 no done", doneSeen, 0);
  endtask

  initial begin
    #(4 * 190000);
    failCnt++;
    testCnt++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    int pres[4];
    int sizes[8];
    pres = '{1, 3, 7, 28};
    sizes = '{0, 1, 2, 5, 17, 63, 64, 65};
    repeat (3) @(posedge clk);
    #1;
    // R1
    chk(wrEn == 1'b0, "R1 wrEn in reset", int'(wrEn), 0);
    chk(frameDone == 1'b0, "R1 frameDone in reset", int'(frameDone), 0);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk);
    #1;
    chk(wrEn == 1'b0, "R1 wrEn after reset", int'(wrEn), 0);
    chk(frameDone == 1'b0, "R1 frameDone after reset", int'(frameDone), 0);

    // R2 R3 R4 R5 R7: sweep preamble length, size and trailing partial dibits
    for (int p = 0; p < 4; p++)
      for (int s = 0; s < 8; s++)
        for (int e = 0; e < 4; e++)
          sendFrame(pres[p], sizes[s], e, p * 32 + s * 4 + e);

    // R8 R9 followed by recovery
    for (int k = 0; k < 4; k++) begin
      badStart(k);
      sendFrame(2, 3, 0, 200 + k);
    end

    // R6: length saturation on a very long frame
    sendFrame(4, 2100, 1, 77);

    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule